// File: doc/BRIEF.md
# Pattern Fill DMA Channel

This block is a single DMA channel that fills a memory range with a repeating 128-bit pattern, for example to give every word of a memory a known value before checking codes are enabled on it. Software programs the channel through a small 32-bit register port. It sets a control word that selects the fill mode, loads four 32-bit pattern words, a 49-bit destination address split over two words and a byte size, and then writes a go bit. The channel never reads a source. It issues one 128-bit write per beat on a valid/ready master port. Each beat carries the same pattern, and the address advances by 16 bytes on every accepted beat.

Before a transfer starts, the channel checks its configuration. A bad mode, a bad pointer type, an unaligned address or a bad size is refused. The channel then goes to an error state and issues no writes. A 2-bit status field shows idle/done, busy or error. A done flag in an interrupt status word drives the interrupt output, and software clears that flag by writing one to it. A byte counter can be read back and shows how many bytes the current or last transfer has written.

Register word offsets on `reg_addr`: 0 control, 1 go, 2 status, 3 interrupt status, 4 to 7 pattern words 0 to 3, 8 destination address low, 9 destination address high, 10 source size, 11 destination size, 12 byte counter.

Top module: `pfill_dma`

## Requirements
- R1: After reset the control word reads 0x80. The pattern words, both address words, both size words and the byte counter read 0. Status bits [1:0] read 00, and `irq` is 0.
- R2: Writing 1 to bit 0 of the go word (offset 1) starts a transfer when the channel is not busy. While beats remain, status [1:0] reads 10 (busy).
- R3: Every write beat carries pattern word 0 in data bits [31:0], word 1 in [63:32], word 2 in [95:64] and word 3 in [127:96].
- R4: The first beat address is {address-high[16:0], address-low[31:0]}. The address and data stay stable while `mem_ready` is low, and the address grows by 16 after every accepted beat.
- R5: A transfer issues exactly size/16 beats, taking the size from offset 11. After the last beat, status reads 00, bit 10 of the interrupt status word (offset 3) is 1 and `irq` is 1.
- R6: Writing a word with bit 10 set to offset 3 clears the done flag and `irq`. Writing 0 there leaves the flag set.
- R7: A start is refused with status 11, with the done flag set and no beats issued, when any of these holds: control bits [5:4] are not 01; control bit 6 is 1; address bits [3:0] are not 0; size bits [3:0] are not 0; the size is above 0x3FFFFFF8; or the source size (offset 10) differs from the destination size.
- R8: The byte counter (offset 12) is cleared on each start and grows by 16 per accepted beat.
- R9: While busy, register writes to the configuration and pattern words are ignored.
- R10: A valid start with size 0 issues no beats, and ends with status 00 and the done flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Write beat accepted |
| mem_addr | output | 49 | Beat byte address |
| mem_data | output | 128 | Beat data |
| irq | output | 1 | Done interrupt |

## Verification
Random fills use random 16-byte-aligned addresses, with random upper address bits and random pattern words. The sizes run from one to eight beats, and `mem_ready` is random so that back-pressure is exercised. These runs tell apart correct address stepping, stalling and word order within a beat. Directed runs cover the refused starts one cause at a time: each bad mode, the pointer bit, the address offset, the size offset, the oversize and the source/destination size mismatch. Together they show that no beat leaks out on any cause. A zero-size start, done-flag clearing with 0 and with 1 written, and a pattern write during a stalled transfer cover the remaining corners.

// File: rtl/pfill_pkg.sv
package pfill_pkg;
    localparam int ADDR_W     = 49;
    localparam int WORD_W     = 32;
    localparam int PAT_WORDS  = 4;
    localparam int DATA_W     = WORD_W * PAT_WORDS;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int ALIGN_B    = $clog2(BEAT_BYTES);
    localparam int HI_W       = ADDR_W - WORD_W;
    localparam int REG_AW     = 4;
    localparam int DONE_BIT   = 10;

    localparam logic [WORD_W-1:0] MAX_SIZE = 32'h3FFF_FFF8;
    localparam logic [WORD_W-1:0] CTRL_RST = 32'h0000_0080;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] OFS_GO    = 4'd1;
    localparam logic [REG_AW-1:0] OFS_STAT  = 4'd2;
    localparam logic [REG_AW-1:0] OFS_ISR   = 4'd3;
    localparam logic [REG_AW-1:0] OFS_PAT0  = 4'd4;
    localparam logic [REG_AW-1:0] OFS_DLO   = 4'd8;
    localparam logic [REG_AW-1:0] OFS_DHI   = 4'd9;
    localparam logic [REG_AW-1:0] OFS_SSZ   = 4'd10;
    localparam logic [REG_AW-1:0] OFS_DSZ   = 4'd11;
    localparam logic [REG_AW-1:0] OFS_TOTAL = 4'd12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b10,
        ST_ERR  = 2'b11
    } chan_state_e;

    typedef struct packed {
        logic [1:0]        mode;
        logic              ptr;
        logic [ADDR_W-1:0] dst;
        logic [WORD_W-1:0] src_size;
        logic [WORD_W-1:0] dst_size;
    } fill_cfg_t;

    function automatic logic cfg_ok(fill_cfg_t c);
        return (c.mode == 2'b01) && !c.ptr
            && (c.dst[ALIGN_B-1:0] == '0)
            && (c.dst_size[ALIGN_B-1:0] == '0)
            && (c.dst_size <= MAX_SIZE)
            && (c.src_size == c.dst_size);
    endfunction
endpackage

// File: rtl/pfill_regs.sv
module pfill_regs
    import pfill_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    input  chan_state_e           state,
    input  logic                  done_set,
    input  logic [WORD_W-1:0]     total,
    output fill_cfg_t             cfg,
    output logic [DATA_W-1:0]     pattern,
    output logic                  start,
    output logic                  done_flag,
    output logic [WORD_W-1:0]     rdata
);
    logic              busy;
    logic [WORD_W-1:0] ctrl_q, dlo_q, ssz_q, dsz_q;
    logic [HI_W-1:0]   dhi_q;
    logic [PAT_WORDS-1:0][WORD_W-1:0] pat_q;
    logic              cfg_wr;

    assign busy   = (state == ST_BUSY);
    assign cfg_wr = wr_en && !busy;
    assign start  = wr_en && (addr == OFS_GO) && wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            dlo_q  <= '0;
            dhi_q  <= '0;
            ssz_q  <= '0;
            dsz_q  <= '0;
        end else if (cfg_wr) begin
            case (addr)
                OFS_CTRL: ctrl_q <= wdata;
                OFS_DLO:  dlo_q  <= wdata;
                OFS_DHI:  dhi_q  <= wdata[HI_W-1:0];
                OFS_SSZ:  ssz_q  <= wdata;
                OFS_DSZ:  dsz_q  <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < PAT_WORDS; i++) begin : g_pat
        always_ff @(posedge clk) begin
            if (rst)
                pat_q[i] <= '0;
            else if (cfg_wr && addr == OFS_PAT0 + REG_AW'(i))
                pat_q[i] <= wdata;
        end
        assign pattern[i*WORD_W +: WORD_W] = pat_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            done_flag <= 1'b0;
        else if (done_set)
            done_flag <= 1'b1;
        else if (wr_en && addr == OFS_ISR && wdata[DONE_BIT])
            done_flag <= 1'b0;
    end

    always_comb begin
        cfg.mode     = ctrl_q[5:4];
        cfg.ptr      = ctrl_q[6];
        cfg.dst      = {dhi_q, dlo_q};
        cfg.src_size = ssz_q;
        cfg.dst_size = dsz_q;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL:  rdata = ctrl_q;
            OFS_GO:    rdata = {{(WORD_W-1){1'b0}}, busy};
            OFS_STAT:  rdata = {{(WORD_W-2){1'b0}}, state};
            OFS_ISR:   rdata = WORD_W'(done_flag) << DONE_BIT;
            OFS_DLO:   rdata = dlo_q;
            OFS_DHI:   rdata = WORD_W'(dhi_q);
            OFS_SSZ:   rdata = ssz_q;
            OFS_DSZ:   rdata = dsz_q;
            OFS_TOTAL: rdata = total;
            default:
                if (addr >= OFS_PAT0 && addr < OFS_PAT0 + REG_AW'(PAT_WORDS))
                    rdata = pat_q[2'(addr - OFS_PAT0)];
        endcase
    end

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_ISR && wdata[DONE_BIT] && !done_set) |=> !done_flag);

    p_pat_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && addr == OFS_PAT0) |=> $stable(pat_q[0]));
endmodule

// File: rtl/pfill_engine.sv
module pfill_engine
    import pfill_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  fill_cfg_t             cfg,
    input  logic [DATA_W-1:0]     pattern,
    input  logic                  mem_ready,
    output logic                  mem_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output chan_state_e           state,
    output logic                  done_set,
    output logic [WORD_W-1:0]     total
);
    chan_state_e       st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] remain_q;
    logic              hs, last, ok;

    assign ok        = cfg_ok(cfg);
    assign mem_valid = (st_q == ST_BUSY);
    assign hs        = mem_valid && mem_ready;
    assign last      = (remain_q == WORD_W'(BEAT_BYTES));
    assign done_set  = (start && (!ok || cfg.dst_size == '0)) || (hs && last);
    assign mem_addr  = addr_q;
    assign mem_data  = pattern;
    assign state     = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            total    <= '0;
        end else if (start) begin
            total <= '0;
            if (!ok)
                st_q <= ST_ERR;
            else if (cfg.dst_size == '0)
                st_q <= ST_IDLE;
            else begin
                st_q     <= ST_BUSY;
                addr_q   <= cfg.dst;
                remain_q <= cfg.dst_size;
            end
        end else if (hs) begin
            addr_q   <= addr_q + ADDR_W'(BEAT_BYTES);
            remain_q <= remain_q - WORD_W'(BEAT_BYTES);
            total    <= total + WORD_W'(BEAT_BYTES);
            if (last)
                st_q <= ST_IDLE;
        end
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    p_align_r4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[ALIGN_B-1:0] == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        hs |=> (!mem_valid || mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done_set |=> (st_q != ST_BUSY));
endmodule

// File: rtl/pfill_dma.sv
module pfill_dma
    import pfill_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output logic                  irq
);
    fill_cfg_t         cfg;
    logic [DATA_W-1:0] pattern;
    logic              start, done_set, done_flag;
    chan_state_e       state;
    logic [WORD_W-1:0] total;

    pfill_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .state(state), .done_set(done_set), .total(total), .cfg(cfg),
        .pattern(pattern), .start(start), .done_flag(done_flag), .rdata(reg_rdata)
    );

    pfill_engine u_engine (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg), .pattern(pattern),
        .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .state(state), .done_set(done_set), .total(total)
    );

    assign irq = done_flag;

    p_no_write_err_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERR) |-> !mem_valid);
endmodule

// File: tb/pfill_dma_tb.sv
module pfill_dma_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_we = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [48:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    int ready_mode = 2;          // 0 random, 1 stall, 2 always ready
    int beats = 0;
    logic [48:0]  exp_base = '0;
    logic [127:0] exp_pat = '0;

    always #2.5 clk = ~clk;

    pfill_dma u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (ready_mode == 0)      mem_ready = ($urandom % 10) < 7;
        else if (ready_mode == 1) mem_ready = 1'b0;
        else                      mem_ready = 1'b1;
    end

    initial forever begin
        @(negedge clk);
        #2;
        if (!rst && mem_valid && mem_ready) begin
            checks++;
            if (mem_addr !== exp_base + 49'(beats) * 49'd16) begin
                fails++;
                $display("FAIL R4 beat addr actual=%0h expected=%0h", mem_addr,
                         exp_base + 49'(beats) * 49'd16);
            end
            checks++;
            if (mem_data !== exp_pat) begin
                fails++;
                $display("FAIL R3 beat data actual=%0h expected=%0h", mem_data, exp_pat);
            end
            beats++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic bit exp_ok(logic [1:0] mode, logic ptr, logic [48:0] a,
                                  logic [31:0] ss, logic [31:0] ds);
        return mode == 2'b01 && !ptr && a[3:0] == 0 && ds[3:0] == 0
            && ds <= 32'h3FFF_FFF8 && ss == ds;
    endfunction

    task automatic run_xfer(input logic [1:0] mode, input logic ptr, input logic [48:0] a,
                            input logic [31:0] ss, input logic [31:0] ds,
                            input logic [127:0] pat, input string tag);
        logic [31:0] v;
        bit ok;
        ok = exp_ok(mode, ptr, a, ss, ds);
        wr(4'd0, (32'(mode) << 4) | (32'(ptr) << 6));
        for (int i = 0; i < 4; i++) wr(4'(4 + i), pat[i*32 +: 32]);
        wr(4'd8, a[31:0]);
        wr(4'd9, 32'(a[48:32]));
        wr(4'd10, ss);
        wr(4'd11, ds);
        wr(4'd3, 32'h400);
        exp_base = a; exp_pat = pat; beats = 0;
        wr(4'd1, 32'd1);
        for (int k = 0; k < 2000; k++) begin
            rd(4'd2, v);
            if (v[1:0] != 2'b10) break;
        end
        repeat (2) @(negedge clk);
        rd(4'd2, v);
        check({tag, " R5/R7 status"}, 64'(v[1:0]), ok ? 64'd0 : 64'd3);
        check({tag, " R5 beat count"}, 64'(beats), ok ? 64'(ds / 16) : 64'd0);
        rd(4'd3, v);
        check({tag, " R5 done bit"}, 64'(v[10]), 64'd1);
        check({tag, " R5 irq"}, 64'(irq), 64'd1);
        rd(4'd12, v);
        check({tag, " R8 total"}, 64'(v), ok ? 64'(ds) : 64'd0);
    endtask

    task automatic main_seq();
        logic [31:0] v;
        logic [127:0] p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd(4'd0, v);  check("R1 ctrl", 64'(v), 64'h80);
        rd(4'd2, v);  check("R1 status", 64'(v), 64'd0);
        rd(4'd4, v);  check("R1 pattern0", 64'(v), 64'd0);
        rd(4'd9, v);  check("R1 addr hi", 64'(v), 64'd0);
        rd(4'd11, v); check("R1 dst size", 64'(v), 64'd0);
        rd(4'd12, v); check("R1 total", 64'(v), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);

        // R7 default control (mode 00) is refused
        wr(4'd1, 32'd1);
        rd(4'd2, v); check("R7 reset ctrl refused", 64'(v), 64'd3);
        check("R7 reset ctrl no beats", 64'(beats), 64'd0);

        // R3/R4/R5 directed, always ready
        ready_mode = 2;
        run_xfer(2'b01, 1'b0, 49'h1_2345_6780, 32'd64, 32'd64,
                 128'h33333333_22222222_11111111_00000000, "dir");

        // R6 clearing
        wr(4'd3, 32'h0);
        check("R6 write0 keeps irq", 64'(irq), 64'd1);
        wr(4'd3, 32'h400);
        check("R6 write1 clears irq", 64'(irq), 64'd0);
        rd(4'd3, v); check("R6 done bit cleared", 64'(v[10]), 64'd0);

        // R2/R9 stalled transfer
        ready_mode = 1;
        wr(4'd0, 32'h10); wr(4'd4, 32'hAAAA_0001); wr(4'd8, 32'h100);
        wr(4'd9, 32'h0); wr(4'd10, 32'd32); wr(4'd11, 32'd32);
        exp_base = 49'h100; beats = 0;
        rd(4'd5, v); exp_pat = {u_dut.mem_data[127:32], 32'hAAAA_0001};
        wr(4'd1, 32'd1);
        rd(4'd2, v); check("R2 busy status", 64'(v), 64'd2);
        check("R2 valid while busy", 64'(mem_valid), 64'd1);
        wr(4'd4, 32'h5555_5555);
        rd(4'd4, v); check("R9 pattern write ignored", 64'(v), 64'hAAAA_0001);
        wr(4'd11, 32'd160);
        rd(4'd11, v); check("R9 size write ignored", 64'(v), 64'd32);
        ready_mode = 2;
        repeat (6) @(negedge clk);
        check("R2 beats after release", 64'(beats), 64'd2);
        rd(4'd2, v); check("R2 back to idle", 64'(v), 64'd0);

        // R7 refusals one cause at a time
        run_xfer(2'b10, 1'b0, 49'h200, 32'd32, 32'd32, 128'h1, "bad mode");
        run_xfer(2'b01, 1'b1, 49'h200, 32'd32, 32'd32, 128'h2, "ptr bit");
        run_xfer(2'b01, 1'b0, 49'h208, 32'd32, 32'd32, 128'h3, "addr offset");
        run_xfer(2'b01, 1'b0, 49'h200, 32'd24, 32'd24, 128'h4, "size offset");
        run_xfer(2'b01, 1'b0, 49'h200, 32'h4000_0000, 32'h4000_0000, 128'h5, "oversize");
        run_xfer(2'b01, 1'b0, 49'h200, 32'd48, 32'd32, 128'h6, "size mismatch");

        // R10 zero size
        run_xfer(2'b01, 1'b0, 49'h300, 32'd0, 32'd0, 128'h7, "R10 zero");

        // random fills with back-pressure
        ready_mode = 0;
        for (int n = 0; n < 8; n++) begin
            logic [48:0] a;
            a = {17'($urandom), $urandom} & ~49'hF;
            p = {$urandom, $urandom, $urandom, $urandom};
            run_xfer(2'b01, 1'b0, a, 32'(16 * (1 + $urandom % 8)),
                     32'(16 * (1 + $urandom % 8)), p, "rand");
        end
        for (int n = 0; n < 6; n++) begin
            logic [48:0] a;
            logic [31:0] s;
            a = {17'($urandom), $urandom} & ~49'hF;
            s = 32'(16 * (1 + $urandom % 8));
            p = {$urandom, $urandom, $urandom, $urandom};
            run_xfer(2'b01, 1'b0, a, s, s, p, "rand ok");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule